// File: doc/BRIEF.md
# Transceiver Management Register Block

This block holds the management registers of an Ethernet transceiver. A host reaches them over a plain parallel port with a 5-bit register address, 16-bit write data, a write strobe and a combinational read-data bus. One control register sets loopback, auto-negotiation enable, restart and manual duplex, and arms a collision self-test. A read-only status register reports fixed capabilities next to four live condition inputs.

The block works with an external auto-negotiation engine. It raises a restart request that stays high until the engine reports, through `an_started`, that negotiation has begun. It takes the negotiated duplex back from the engine and resolves it against loopback and the manual setting, then drives the duplex the link should use. While loopback and the collision test are both on, a bit-time counter turns the transmit enable into a delayed collision indication. The bit rate reaches the counter through a one-cycle bit tick.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control register reads 0x1000 (only auto-negotiation enable set). The status register reads 0x7849 with all live inputs low. `an_restart` and `col` are 0.
- R2: Control register is at address 0. Loopback is bit 14, auto-negotiation enable is bit 12, restart is bit 9, manual duplex is bit 8 and collision test is bit 7. All other bits read 0 and ignore writes.
- R3: The status register is at address 1 and is read-only. A write to address 1 changes neither the status value nor the control register.
- R4: Status bits 5 (negotiation complete), 4 (remote fault), 2 (link up) and 1 (jabber) follow the inputs `an_complete`, `remote_fault`, `link_up` and `jabber` in the same cycle.
- R5: A write that sets restart raises `an_restart` one clock after the write, but only if the same write also sets auto-negotiation enable.
- R6: `an_restart` clears one clock after `an_started` is sampled high, unless a control write happens in that cycle.
- R7: Writing auto-negotiation enable as 0 clears restart, and `an_restart` is never high while enable is 0.
- R8: `duplex_eff` is 1 while loopback is set. Otherwise it equals `an_result_fdx` while auto-negotiation is enabled, and equals the manual duplex bit when negotiation is disabled.
- R9: `col` stays 0 unless loopback and collision test are both set.
- R10: In collision test, `col` rises one clock after the 64th bit tick counted with `tx_en` high. This is well inside a 512 bit-time limit.
- R11: In collision test, `col` falls one clock after the first bit tick seen with `tx_en` low.
- R12: Reads from any address other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| an_started | input | 1 | Negotiation engine has begun a negotiation |
| an_result_fdx | input | 1 | Negotiated duplex, 1 = full |
| an_complete | input | 1 | Live negotiation-complete condition |
| remote_fault | input | 1 | Live remote-fault condition |
| link_up | input | 1 | Live link condition |
| jabber | input | 1 | Live jabber condition |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| an_restart | output | 1 | Restart request to the negotiation engine |
| duplex_eff | output | 1 | Effective duplex, 1 = full |
| col | output | 1 | Collision indication |

## Verification
Read data and the status bits are combinational, so the bench checks them in the same cycle as the address or input change, after a short settle delay. Control writes, restart set and clear, and the duplex result all depend on one register stage. The bench drives a write on a falling edge and checks on the next falling edge, after the capturing rising edge. For collision timing, each bit tick is driven for one clock. `col` is checked on the falling edge after the tick's capturing edge. The check after tick 63 expects 0 and the check after tick 64 expects 1. After `tx_en` falls, `col` is checked both before and after the first tick.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int MGMT_ADDR_W = 5;
    localparam int MGMT_DATA_W = 16;

    localparam logic [MGMT_ADDR_W-1:0] ADDR_CTRL = 5'd0;
    localparam logic [MGMT_ADDR_W-1:0] ADDR_STAT = 5'd1;

    // control field positions
    localparam int CB_LOOP    = 14;
    localparam int CB_AN_EN   = 12;
    localparam int CB_RESTART = 9;
    localparam int CB_DUPLEX  = 8;
    localparam int CB_COLTEST = 7;

    // status field positions
    localparam int SB_T4      = 15;
    localparam int SB_TX_FD   = 14;
    localparam int SB_TX_HD   = 13;
    localparam int SB_10_FD   = 12;
    localparam int SB_10_HD   = 11;
    localparam int SB_PRE_SUP = 6;
    localparam int SB_AN_DONE = 5;
    localparam int SB_RFAULT  = 4;
    localparam int SB_AN_ABL  = 3;
    localparam int SB_LINK    = 2;
    localparam int SB_JABBER  = 1;
    localparam int SB_EXTCAP  = 0;

    typedef struct packed {
        logic loopback;
        logic an_en;
        logic restart;
        logic duplex;
        logic coltest;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{loopback: 1'b0, an_en: 1'b1,
                                     restart: 1'b0, duplex: 1'b0,
                                     coltest: 1'b0};

    typedef struct packed {
        logic an_complete;
        logic remote_fault;
        logic link_up;
        logic jabber;
    } live_t;

    typedef struct packed {
        logic t4;
        logic tx_fd;
        logic tx_hd;
        logic b10_fd;
        logic b10_hd;
        logic pre_sup;
        logic an_abl;
        logic ext_cap;
    } caps_t;

    localparam caps_t CAPS_DEFAULT = '{t4: 1'b0, tx_fd: 1'b1, tx_hd: 1'b1,
                                       b10_fd: 1'b1, b10_hd: 1'b1,
                                       pre_sup: 1'b1, an_abl: 1'b1,
                                       ext_cap: 1'b1};

    typedef enum logic [1:0] {
        DSRC_LOOP   = 2'd0,
        DSRC_NEGOT  = 2'd1,
        DSRC_MANUAL = 2'd2
    } dsrc_e;

    function automatic ctrl_t ctrl_unpack(input logic [MGMT_DATA_W-1:0] w);
        ctrl_t c;
        c.loopback = w[CB_LOOP];
        c.an_en    = w[CB_AN_EN];
        c.restart  = w[CB_RESTART];
        c.duplex   = w[CB_DUPLEX];
        c.coltest  = w[CB_COLTEST];
        return c;
    endfunction

    function automatic logic [MGMT_DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [MGMT_DATA_W-1:0] w;
        w = '0;
        w[CB_LOOP]    = c.loopback;
        w[CB_AN_EN]   = c.an_en;
        w[CB_RESTART] = c.restart;
        w[CB_DUPLEX]  = c.duplex;
        w[CB_COLTEST] = c.coltest;
        return w;
    endfunction

    function automatic logic [MGMT_DATA_W-1:0] stat_pack(input caps_t k,
                                                         input live_t l);
        logic [MGMT_DATA_W-1:0] w;
        w = '0;
        w[SB_T4]      = k.t4;
        w[SB_TX_FD]   = k.tx_fd;
        w[SB_TX_HD]   = k.tx_hd;
        w[SB_10_FD]   = k.b10_fd;
        w[SB_10_HD]   = k.b10_hd;
        w[SB_PRE_SUP] = k.pre_sup;
        w[SB_AN_ABL]  = k.an_abl;
        w[SB_EXTCAP]  = k.ext_cap;
        w[SB_AN_DONE] = l.an_complete;
        w[SB_RFAULT]  = l.remote_fault;
        w[SB_LINK]    = l.link_up;
        w[SB_JABBER]  = l.jabber;
        return w;
    endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  ctrl_t wr_val,
    input  logic  an_started,
    output ctrl_t ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            ctrl_d         = wr_val;
            // restart only survives a write that also enables negotiation
            ctrl_d.restart = wr_val.restart & wr_val.an_en;
        end else if (an_started) begin
            ctrl_d.restart = 1'b0;
        end
        if (!ctrl_d.an_en) begin
            ctrl_d.restart = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/phy_duplex_sel.sv
module phy_duplex_sel
    import phy_mgmt_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  negot_fdx,
    output logic  duplex_out
);

    dsrc_e src;

    always_comb begin
        if (ctrl.loopback) begin
            src = DSRC_LOOP;
        end else if (ctrl.an_en) begin
            src = DSRC_NEGOT;
        end else begin
            src = DSRC_MANUAL;
        end
    end

    always_comb begin
        unique case (src)
            DSRC_LOOP:   duplex_out = 1'b1;
            DSRC_NEGOT:  duplex_out = negot_fdx;
            DSRC_MANUAL: duplex_out = ctrl.duplex;
            default:     duplex_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/phy_coltest.sv
module phy_coltest #(
    parameter int COL_DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bit_tick,
    input  logic tx_en,
    output logic col
);

    localparam int CNT_W = $clog2(COL_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COL_DELAY - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             col_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
            col_q <= 1'b0;
        end else if (bit_tick) begin
            if (tx_en) begin
                if (cnt_q >= CNT_LAST) begin
                    col_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
                col_q <= 1'b0;
            end
        end
    end

    assign col = col_q & active;

endmodule

// File: rtl/phy_status_view.sv
module phy_status_view
    import phy_mgmt_pkg::*;
#(
    parameter int    DATA_W = MGMT_DATA_W,
    parameter caps_t CAPS   = CAPS_DEFAULT
) (
    input  live_t             live,
    output logic [DATA_W-1:0] status_word
);

    assign status_word = DATA_W'(stat_pack(CAPS, live));

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W    = MGMT_ADDR_W,
    parameter int DATA_W    = MGMT_DATA_W,
    parameter int COL_DELAY = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              an_started,
    input  logic              an_result_fdx,
    input  logic              an_complete,
    input  logic              remote_fault,
    input  logic              link_up,
    input  logic              jabber,
    input  logic              bit_tick,
    input  logic              tx_en,
    output logic              an_restart,
    output logic              duplex_eff,
    output logic              col
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    ctrl_t             ctrl_q;
    ctrl_t             wr_val;
    logic              ctrl_hit;
    live_t             live;
    logic [DATA_W-1:0] stat_word;
    logic              col_active;

    assign ctrl_hit = reg_we && (reg_addr == A_CTRL);
    assign wr_val   = ctrl_unpack(MGMT_DATA_W'(reg_wdata));

    phy_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (ctrl_hit),
        .wr_val     (wr_val),
        .an_started (an_started),
        .ctrl_q     (ctrl_q)
    );

    phy_duplex_sel u_dsel (
        .ctrl       (ctrl_q),
        .negot_fdx  (an_result_fdx),
        .duplex_out (duplex_eff)
    );

    assign col_active = ctrl_q.loopback & ctrl_q.coltest;

    phy_coltest #(
        .COL_DELAY (COL_DELAY)
    ) u_col (
        .clk      (clk),
        .rst      (rst),
        .active   (col_active),
        .bit_tick (bit_tick),
        .tx_en    (tx_en),
        .col      (col)
    );

    assign live = '{an_complete: an_complete, remote_fault: remote_fault,
                    link_up: link_up, jabber: jabber};

    phy_status_view #(
        .DATA_W (DATA_W)
    ) u_stat (
        .live        (live),
        .status_word (stat_word)
    );

    always_comb begin
        if (reg_addr == A_CTRL) begin
            reg_rdata = DATA_W'(ctrl_pack(ctrl_q));
        end else if (reg_addr == A_STAT) begin
            reg_rdata = stat_word;
        end else begin
            reg_rdata = '0;
        end
    end

    assign an_restart = ctrl_q.restart;

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              an_started,
    input logic              an_restart,
    input logic              an_en_q,
    input logic              loop_q,
    input logic              coltest_q,
    input logic              bit_tick,
    input logic              tx_en,
    input logic              duplex_eff,
    input logic              col
);

    AST_RESTART_NEEDS_AN_EN: assert property (@(posedge clk) disable iff (rst)
        an_restart |-> an_en_q);  // R7

    AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (an_restart && an_started && !reg_we) |=> !an_restart);  // R6

    AST_COL_NEEDS_TEST_MODE: assert property (@(posedge clk) disable iff (rst)
        col |-> (loop_q && coltest_q));  // R9

    AST_LOOPBACK_FULL_DUPLEX: assert property (@(posedge clk) disable iff (rst)
        loop_q |-> duplex_eff);  // R8

    AST_COL_DROP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !tx_en) |=> !col);  // R11

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > ADDR_W'(1)) |-> (reg_rdata == '0));  // R12

endmodule

bind phy_mgmt_regs phy_mgmt_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .an_started (an_started),
    .an_restart (an_restart),
    .an_en_q    (ctrl_q.an_en),
    .loop_q     (ctrl_q.loopback),
    .coltest_q  (ctrl_q.coltest),
    .bit_tick   (bit_tick),
    .tx_en      (tx_en),
    .duplex_eff (duplex_eff),
    .col        (col)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        an_started = 1'b0;
    logic        an_result_fdx = 1'b0;
    logic        an_complete = 1'b0;
    logic        remote_fault = 1'b0;
    logic        link_up = 1'b0;
    logic        jabber = 1'b0;
    logic        bit_tick = 1'b0;
    logic        tx_en = 1'b0;
    logic        an_restart;
    logic        duplex_eff;
    logic        col;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phy_mgmt_regs u_dut (
        .clk (clk), .rst (rst), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_we (reg_we), .reg_rdata (reg_rdata), .an_started (an_started),
        .an_result_fdx (an_result_fdx), .an_complete (an_complete),
        .remote_fault (remote_fault), .link_up (link_up), .jabber (jabber),
        .bit_tick (bit_tick), .tx_en (tx_en), .an_restart (an_restart),
        .duplex_eff (duplex_eff), .col (col)
    );

    // {wdata, an_result_fdx, expected duplex_eff, expected control readback}
    localparam logic [33:0] VEC [8] = '{
        {16'h0100, 1'b0, 1'b1, 16'h0100},
        {16'h0000, 1'b1, 1'b0, 16'h0000},
        {16'h1100, 1'b0, 1'b0, 16'h1100},
        {16'h1000, 1'b1, 1'b1, 16'h1000},
        {16'h4000, 1'b0, 1'b1, 16'h4000},
        {16'h4100, 1'b0, 1'b1, 16'h4100},
        {16'hFFFF, 1'b0, 1'b1, 16'h5380},
        {16'h0200, 1'b1, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a,
                            input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 ctrl reset", 5'd0, 16'h1000);
        rd_check("R1 status reset", 5'd1, 16'h7849);
        check("R1 restart reset", {15'd0, an_restart}, 16'd0);
        check("R1 col reset", {15'd0, col}, 16'd0);

        // R2 / R8 / R5 / R7 table walk
        for (int i = 0; i < 8; i++) begin
            an_result_fdx = VEC[i][17];
            wr(5'd0, VEC[i][33:18]);
            check($sformatf("R8 duplex vec%0d", i), {15'd0, duplex_eff},
                  {15'd0, VEC[i][16]});
            rd_check($sformatf("R2 ctrl readback vec%0d", i), 5'd0, VEC[i][15:0]);
        end

        // R4 live status bits
        an_complete = 1'b1; link_up = 1'b1;
        rd_check("R4 status live a", 5'd1, 16'h7869 | 16'h0004);
        an_complete = 1'b0; link_up = 1'b0; remote_fault = 1'b1; jabber = 1'b1;
        rd_check("R4 status live b", 5'd1, 16'h7849 | 16'h0012);
        remote_fault = 1'b0; jabber = 1'b0;

        // R3 status is read-only
        wr(5'd0, 16'h1100);
        wr(5'd1, 16'h0000);
        rd_check("R3 status after write", 5'd1, 16'h7849);
        rd_check("R3 ctrl untouched", 5'd0, 16'h1100);

        // R12 unmapped reads
        wr(5'd5, 16'hFFFF);
        rd_check("R12 addr 2", 5'd2, 16'h0000);
        rd_check("R12 addr 31", 5'd31, 16'h0000);
        rd_check("R12 write ignored ctrl", 5'd0, 16'h1100);

        // R5 / R6 restart handshake
        wr(5'd0, 16'h1200);
        check("R5 restart raised", {15'd0, an_restart}, 16'd1);
        repeat (3) @(negedge clk);
        check("R6 restart held", {15'd0, an_restart}, 16'd1);
        an_started = 1'b1;
        @(negedge clk);
        an_started = 1'b0;
        check("R6 restart cleared", {15'd0, an_restart}, 16'd0);
        rd_check("R6 ctrl after clear", 5'd0, 16'h1000);

        // R7 disabling negotiation drops restart
        wr(5'd0, 16'h1200);
        check("R7 restart set before", {15'd0, an_restart}, 16'd1);
        wr(5'd0, 16'h0200);
        check("R7 restart dropped", {15'd0, an_restart}, 16'd0);

        // R9 collision gating
        wr(5'd0, 16'h0080);
        tx_en = 1'b1;
        for (int k = 0; k < 70; k++) tick();
        check("R9 col coltest only", {15'd0, col}, 16'd0);
        tx_en = 1'b0;
        wr(5'd0, 16'h4000);
        tx_en = 1'b1;
        for (int k = 0; k < 70; k++) tick();
        check("R9 col loopback only", {15'd0, col}, 16'd0);
        tx_en = 1'b0;

        // R10 / R11 collision timing
        wr(5'd0, 16'h4080);
        tx_en = 1'b1;
        for (int k = 0; k < 63; k++) tick();
        check("R10 col low after 63 ticks", {15'd0, col}, 16'd0);
        tick();
        check("R10 col high after 64 ticks", {15'd0, col}, 16'd1);
        @(negedge clk);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 col held before tick", {15'd0, col}, 16'd1);
        tick();
        check("R11 col low after tick", {15'd0, col}, 16'd0);
        tx_en = 1'b1;
        for (int k = 0; k < 64; k++) tick();
        check("R10 col again after restart", {15'd0, col}, 16'd1);
        wr(5'd0, 16'h0080);
        check("R9 col off when loopback cleared", {15'd0, col}, 16'd0);
        tx_en = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule